// File: doc/BRIEF.md
# Posted-Write Watchdog Timer

This block is a 32-bit watchdog counter that counts upward on a slow functional time base. Software reaches it through a single-cycle register bus that runs on the fast bus clock. The slow domain is represented by a one-cycle `tick` strobe that is synchronous to the bus clock. Writes that target the slow domain are posted. Each write is held in a shadow register, and a per-register pending flag stays set until the next tick commits the value.

Software chooses a prescale ratio and a reload value while the timer is stopped. It starts or stops the timer with an ordered pair of key words, and it keeps the system alive by writing the trigger register with a fresh value. If the counter rolls past all-ones, the block emits a single-cycle reset pulse and starts over from the reload value.

Top module: `wdt_posted`

## Requirements
- R1: After reset the following all read zero: the control, counter, load, trigger, pending and run-status registers. `wdt_rst` is low. The low byte of the identification register (word address 0) reads `REV_CODE`.
- R2: Each posted register has a pending bit in the pending register (word address 5): control is bit 0, load is bit 2, trigger is bit 3 and key is bit 4. An accepted write sets its bit on the next cycle. The bit clears, and the value takes effect, at the first tick after the write cycle. A write to a register whose bit is still set is dropped.
- R3: Applying 0xBBBB and then 0x4444 as consecutive key values (word address 6) starts the timer. While the timer runs, a read of the key address returns 1 in bit 0.
- R4: Applying 0xAAAA and then 0x5555 as consecutive key values stops the timer, and the key read returns 0.
- R5: Any other key value clears the partial sequence and leaves the run state unchanged. This includes a second word that does not match the first word preceding it.
- R6: While running, the counter (word address 2) advances once per tick when control bit 5 is clear. When bit 5 is set, it advances once every 2^p ticks, where p is control bits 4:2. While stopped, the counter holds its value.
- R7: A committed trigger value (word address 4) that differs from the current one reloads the counter from the load register (word address 3) and restarts the prescale phase. A committed trigger value equal to the current one has no effect.
- R8: While the timer runs, writes to the control (word address 1) and load registers are ignored. They set no pending bit and change no value.
- R9: When the counter advances from 0xFFFFFFFF, it reloads from the load register and `wdt_rst` is high for exactly one clock.
- R10: Reads return the register selected by `bus_addr` when `bus_sel` is high and `bus_we` is low. Otherwise, and for unused addresses, reads return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle functional time-base strobe |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The counter is run with the prescaler off, at ratio 1 and at ratio 4. The tick strobe is applied every cycle, every second cycle and every third cycle, which separates the prescale phase from the tick spacing. Some writes land in a tick cycle and some land on a still-pending register, which distinguishes immediate commitment from commitment at the following tick. The key tests use correct pairs, crossed pairs, stray words and a repeated trigger value. These show whether the detector tracks only adjacent committed words and whether a reload depends on the trigger value changing. A load value just below all-ones checks both the pulse width and the eight-tick spacing between successive wraps.

// File: rtl/wdt_posted.sv
module wdt_posted #(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter logic [7:0] REV_CODE = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wdt_rst
);
  localparam int NSLOT = 4;
  localparam int PTV_W = 3;
  localparam int DIV_W = (1 << PTV_W) - 1;
  localparam logic [AW-1:0] A_REV  = AW'(0);
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam logic [AW-1:0] A_CNT  = AW'(2);
  localparam logic [AW-1:0] A_LOAD = AW'(3);
  localparam logic [AW-1:0] A_TRIG = AW'(4);
  localparam logic [AW-1:0] A_PEND = AW'(5);
  localparam logic [AW-1:0] A_KEY  = AW'(6);
  localparam logic [DW-1:0] KEY_EN_A  = DW'(16'hBBBB);
  localparam logic [DW-1:0] KEY_EN_B  = DW'(16'h4444);
  localparam logic [DW-1:0] KEY_DIS_A = DW'(16'hAAAA);
  localparam logic [DW-1:0] KEY_DIS_B = DW'(16'h5555);

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_EN, SEQ_DIS} seq_t;

  logic [NSLOT-1:0] pend, hit, lock, acc, apply;
  logic [DW-1:0]    shadow [NSLOT];
  logic [DW-1:0]    cnt_q, load_q, trig_q;
  logic [PTV_W:0]   ctrl_q;
  logic [DIV_W-1:0] div_q, div_lim;
  logic [DIV_W:0]   lim_full;
  logic             running, reload, step, wrap;
  seq_t             seq_q;

  assign hit   = {bus_addr == A_KEY, bus_addr == A_TRIG, bus_addr == A_LOAD, bus_addr == A_CTRL};
  assign lock  = {2'b00, running, running};
  assign acc   = (bus_sel && bus_we) ? (hit & ~pend & ~lock) : '0;
  assign apply = tick ? pend : '0;

  assign lim_full = ((DIV_W+1)'(1) << ctrl_q[PTV_W-1:0]) - (DIV_W+1)'(1);
  assign div_lim  = ctrl_q[PTV_W] ? lim_full[DIV_W-1:0] : '0;
  assign reload   = apply[2] && (shadow[2] != trig_q);
  assign step     = tick && running && !reload && (div_q >= div_lim);
  assign wrap     = step && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      for (int i = 0; i < NSLOT; i++) shadow[i] <= '0;
    end else begin
      pend <= acc | (pend & ~apply);
      for (int i = 0; i < NSLOT; i++)
        if (acc[i]) shadow[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      load_q  <= '0;
      trig_q  <= '0;
      ctrl_q  <= '0;
      div_q   <= '0;
      running <= 1'b0;
      seq_q   <= SEQ_IDLE;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= wrap;
      if (reload || wrap) cnt_q <= load_q;
      else if (step)      cnt_q <= cnt_q + DW'(1);
      if (reload || !running) div_q <= '0;
      else if (tick)          div_q <= (div_q >= div_lim) ? '0 : div_q + DIV_W'(1);
      if (apply[0]) ctrl_q <= shadow[0][5:2];
      if (apply[1]) load_q <= shadow[1];
      if (apply[2]) trig_q <= shadow[2];
      if (apply[3]) begin
        if (shadow[3] == KEY_EN_A)       seq_q <= SEQ_EN;
        else if (shadow[3] == KEY_DIS_A) seq_q <= SEQ_DIS;
        else begin
          seq_q <= SEQ_IDLE;
          if (shadow[3] == KEY_EN_B && seq_q == SEQ_EN)   running <= 1'b1;
          if (shadow[3] == KEY_DIS_B && seq_q == SEQ_DIS) running <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        A_REV:   bus_rdata = DW'(REV_CODE);
        A_CTRL:  bus_rdata = DW'({ctrl_q, 2'b00});
        A_CNT:   bus_rdata = cnt_q;
        A_LOAD:  bus_rdata = load_q;
        A_TRIG:  bus_rdata = trig_q;
        A_PEND:  bus_rdata = DW'({pend[3], pend[2], pend[1], 1'b0, pend[0]});
        A_KEY:   bus_rdata = DW'(running);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R9
  wrst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  // R9
  wrst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(&cnt_q) && $past(running));
  // R2
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((pend & $past(pend)) == $past(pend)));
  // R8
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pend[1:0] == 2'b00) |=> pend[1:0] == 2'b00);
  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !(tick && pend[2])) |=> $stable(cnt_q));
  // R3
  run_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running != $past(running)) |-> $past(tick && pend[3]));
endmodule

// File: tb/wdt_posted_test.sv
`timescale 1ns/1ps
module wdt_posted_test;
  localparam logic [7:0] REV = 8'h5A;
  localparam logic [2:0] AR = 3'd0, AC = 3'd1, AN = 3'd2, AL = 3'd3, AT = 3'd4, AP = 3'd5, AK = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sel = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  wire [31:0] rdata;
  wire wrst;

  always #4 clk = ~clk;

  wdt_posted #(.DW(32), .AW(3), .REV_CODE(REV)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .wdt_rst(wrst));

  int n_chk = 0, n_bad = 0, tperiod = 3, cyc_n = 0, rr = 0, pulses = 0;
  bit done = 0;

  logic [31:0] m_ctrl, m_cnt, m_load, m_trig;
  logic [31:0] m_sh [4];
  logic [3:0]  m_pend;
  int          m_div, m_seq;
  bit          m_run, m_wrst;
  logic [31:0] o_ctrl, o_cnt, o_load, o_trig, v;
  logic [31:0] o_sh [4];
  logic [3:0]  o_pend;
  int          o_div, lim, j;
  bit          o_run, rl;

  function automatic int slot_of(logic [2:0] a);
    case (a)
      AC: return 0;
      AL: return 1;
      AT: return 2;
      AK: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      AR: return {24'b0, REV};
      AC: return m_ctrl;
      AN: return m_cnt;
      AL: return m_load;
      AT: return m_trig;
      AP: return {27'b0, m_pend[3], m_pend[2], m_pend[1], 1'b0, m_pend[0]};
      AK: return {31'b0, m_run};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      AC, AL: return "R8 ctrl/load";
      AN: return "R6 counter";
      AT: return "R7 trigger";
      AP: return "R2 pending";
      AK: return "R3 run state";
      default: return "R10 read";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, expv, cyc_n);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_load = 0; m_trig = 0; m_div = 0; m_seq = 0;
      m_run = 0; m_wrst = 0; m_pend = 0;
      for (int i = 0; i < 4; i++) m_sh[i] = 0;
    end else begin
      o_ctrl = m_ctrl; o_cnt = m_cnt; o_load = m_load; o_trig = m_trig;
      o_div = m_div; o_run = m_run; o_pend = m_pend;
      for (int i = 0; i < 4; i++) o_sh[i] = m_sh[i];
      m_wrst = 0;
      lim = o_ctrl[5] ? ((1 << o_ctrl[4:2]) - 1) : 0;
      rl = tick && o_pend[2] && (o_sh[2] != o_trig);
      if (rl) begin
        m_cnt = o_load; m_div = 0;
      end else if (!o_run) begin
        m_div = 0;
      end else if (tick) begin
        if (o_div >= lim) begin
          m_div = 0;
          if (o_cnt == 32'hFFFF_FFFF) begin m_cnt = o_load; m_wrst = 1; end
          else m_cnt = o_cnt + 1;
        end else m_div = o_div + 1;
      end
      if (tick) begin
        if (o_pend[0]) m_ctrl = o_sh[0] & 32'h3C;
        if (o_pend[1]) m_load = o_sh[1];
        if (o_pend[2]) m_trig = o_sh[2];
        if (o_pend[3]) begin
          v = o_sh[3];
          if (v == 32'hBBBB) m_seq = 1;
          else if (v == 32'hAAAA) m_seq = 2;
          else begin
            if (v == 32'h4444 && m_seq == 1) m_run = 1;
            if (v == 32'h5555 && m_seq == 2) m_run = 0;
            m_seq = 0;
          end
        end
        m_pend = m_pend & ~o_pend;
      end
      j = slot_of(addr);
      if (sel && we && j >= 0 && !o_pend[j] && !(j < 2 && o_run)) begin
        m_sh[j] = wdata;
        m_pend[j] = 1'b1;
      end
    end
  end

  task automatic step(bit s, bit w, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    if (rst_n) begin
      chk("R9 wdt_rst", {31'b0, wrst}, {31'b0, m_wrst});
      if (sel && !we) chk(tag_of(addr), rdata, exp_rd(addr));
      if (wrst) pulses++;
    end
    sel = s; we = w; addr = a; wdata = d;
    cyc_n++;
    tick = (cyc_n % tperiod) == 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      step(1, 0, rr[2:0], 0);
      rr = (rr + 1) % 8;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    step(1, 1, a, d);
  endtask

  task automatic settle();
    idle(2 * tperiod + 2);
  endtask

  task automatic rd_check(string tag, logic [2:0] a, logic [31:0] expv);
    step(1, 0, a, 0);
    #1 chk(tag, rdata, expv);
  endtask

  task automatic key_pair(logic [31:0] k1, logic [31:0] k2);
    wr(AK, k1); settle(); wr(AK, k2); settle();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_check("R1 revision", AR, {24'b0, REV});
    rd_check("R1 pending", AP, 0);
    rd_check("R1 run", AK, 0);
    rd_check("R1 counter", AN, 0);
    chk("R1 wdt_rst", {31'b0, wrst}, 0);
    rd_check("R10 unused address", 3'd7, 0);
    // R2 posting and dropped write while pending
    wr(AC, 32'h28);
    wr(AC, 32'h3C);
    rd_check("R2 pending ctrl bit0", AP, 32'h1);
    settle();
    rd_check("R2 dropped write", AC, 32'h28);
    rd_check("R2 cleared", AP, 0);
    wr(AL, 32'h100); settle();
    wr(AT, 32'h1); settle();
    rd_check("R7 reload while stopped", AN, 32'h100);
    // R3 start
    key_pair(32'hBBBB, 32'h4444);
    rd_check("R3 started", AK, 1);
    idle(200);
    // R8 locked writes
    wr(AC, 32'h0);
    rd_check("R8 no pending", AP, 0);
    wr(AL, 32'h5);
    settle();
    rd_check("R8 ctrl kept", AC, 32'h28);
    rd_check("R8 load kept", AL, 32'h100);
    wr(AT, 32'h1); idle(40);
    wr(AT, 32'h2); idle(40);
    // R5 broken sequences
    key_pair(32'hAAAA, 32'h4444);
    rd_check("R5 crossed pair", AK, 1);
    key_pair(32'h1234, 32'h5555);
    rd_check("R5 stray word", AK, 1);
    key_pair(32'hBBBB, 32'h5555);
    rd_check("R5 mismatched second", AK, 1);
    // R4 stop
    key_pair(32'hAAAA, 32'h5555);
    rd_check("R4 stopped", AK, 0);
    step(1, 0, AN, 0);
    #1 held = rdata;
    idle(30);
    rd_check("R6 hold while stopped", AN, held);
    wr(AT, 32'h2); settle();
    rd_check("R7 same trigger no reload", AN, held);
    wr(AT, 32'h7); settle();
    rd_check("R7 changed trigger reloads", AN, 32'h100);
    // R6 prescaler ratio 1, tick every 2 cycles
    tperiod = 2;
    wr(AC, 32'h20); settle();
    key_pair(32'hBBBB, 32'h4444);
    idle(80);
    key_pair(32'hAAAA, 32'h5555);
    // R9 overflow, tick every cycle
    tperiod = 1;
    wr(AC, 32'h0); settle();
    wr(AL, 32'hFFFF_FFF8); settle();
    wr(AT, 32'h8); settle();
    key_pair(32'hBBBB, 32'h4444);
    pulses = 0;
    for (int i = 0; i < 40 && pulses == 0; i++) idle(1);
    chk("R9 first wrap seen", pulses, 1);
    pulses = 0;
    idle(7);
    chk("R9 no pulse inside interval", pulses, 0);
    idle(1);
    chk("R9 next wrap after 8 ticks", pulses, 1);
    idle(30);
    key_pair(32'hAAAA, 32'h5555);
    idle(10);
    done = 1;
    summary();
    $finish;
  end
endmodule